// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block turns single-word host reads and writes into the multiplexed row and column strobe sequences of a 1M x 32 EDO DRAM module. The module is built from two x16 devices. The host presents a 20-bit word address, 32-bit write data and a 4-bit byte enable. The block drives a shared 10-bit address bus, one RAS line per x16 device, one CAS line per byte lane, WE and OE. It captures read data from the DRAM and returns it to the host with a one-cycle done pulse.

After an access the row stays open. A later request to the same row costs only a new CAS cycle. A request to another row first precharges the open row and then opens the new one. A page that stays open past a programmable age limit is closed on its own. A separate refresh arbiter owns the grant input. While the grant is low the block accepts nothing, closes any open row and reports an idle bus once precharge has finished.

Host protocol: the host holds a request, with stable fields, until it sees done. The cycle that carries done is a dead cycle, and a new request is considered from the cycle after it. Timing counts are in clock cycles (20 ns at 50 MHz): ROW_CYC = 1, CAS_CYC = 2, RP_CYC = 2 by default.

Top module: `edo_ctrl`

## Requirements
- R1: While reset is held low, both RAS lines, all four CAS lines, WE and OE are high (inactive), the data-bus enable is low, done is low and the idle flag is high.
- R2: The row is addr[19:10] and is on the address pins when RAS falls. The column is addr[9:0] and is on the address pins when CAS falls.
- R3: Both RAS lines always switch together, and no CAS line is ever low while RAS is high.
- R4: On a write, CAS line i is pulled low exactly when byte enable bit i is set. Line 0 covers data bits 7:0 and line 3 covers bits 31:24. On a read all four CAS lines go low.
- R5: A write is an early write. WE is already low in the cycle before CAS falls and stays low while CAS is low. OE stays high, the write data is driven on the bus and the data-bus enable is high.
- R6: A read holds OE low while CAS is low and leaves the data bus undriven. The DRAM data is captured in the last CAS cycle and appears on rdata in the done cycle.
- R7: When a request is raised with the bus idle, RAS falls on the next edge. RAS stays low at least two cycles before CAS falls, and CAS stays low for CAS_CYC cycles. Done is seen ROW_CYC+CAS_CYC+2 edges after the request is raised (5 by default).
- R8: A request to the open row produces no new RAS fall. Done is seen CAS_CYC+2 edges after the request (4 by default).
- R9: A request to a different row raises RAS for at least RP_CYC+1 cycles, then opens the new row with one RAS fall. Done is seen RP_CYC+ROW_CYC+CAS_CYC+3 edges after the request (8 by default).
- R10: An open row is closed once PAGE_LIMIT cycles have passed since its RAS fell, even with no request pending. RAS is never low for more than PAGE_LIMIT+CAS_CYC+4 cycles.
- R11: While grant is low, an open row is closed and the idle flag rises after precharge. A raised request is not started (RAS stays high, no done). When grant returns, the request is served with the R7 latency.
- R12: Done is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Bus granted to host traffic by the refresh arbiter |
| req_i | input | 1 | Host request, held until done |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Word address: row in 19:10, column in 9:0 |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables, bit i for data bits 8i+7:8i |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with done |
| bus_idle_o | output | 1 | No row open and precharge complete |
| dram_a_o | output | 10 | Multiplexed row/column address |
| dram_ras_n_o | output | 2 | Row strobes: bit 0 low-half device, bit 1 high-half device |
| dram_cas_n_o | output | 4 | Column strobes, one per byte lane |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_dq_o | output | 32 | Data to the DRAM |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 32 | Data from the DRAM |

## Verification
The bench targets the difference between page hits and misses. A design that compared the wrong row bits, or dropped the open-row state, would show an extra RAS fall and a longer latency on a hit, or return data from the wrong row on a miss. Partial writes are merged and read back, so a CAS lane mapped to the wrong byte, or a write that also pulses a disabled lane, shows up as corrupted bytes. Late WE and OE and the bus enable are checked at each CAS fall. The page-age close and the grant handover are checked through the idle flag and RAS. A controller that let a row live forever, or started a cycle without the grant, would leave RAS low or report done early.

// File: rtl/edo_pkg.sv
package edo_pkg;
  parameter int unsigned ROW_W  = 10;
  parameter int unsigned COL_W  = 10;
  parameter int unsigned ADDR_W = ROW_W + COL_W;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned DEV_W  = 16;
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned DEVS  = DATA_W / DEV_W;
  localparam int unsigned PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COLA, ST_CAS, ST_OPEN, ST_PRE
  } edo_st_e;

  typedef struct packed {
    logic              we;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] wdata;
    logic [LANES-1:0]  be;
  } edo_cmd_t;
endpackage

// File: rtl/edo_page_track.sv
module edo_page_track
  import edo_pkg::*;
#(
  parameter int unsigned PAGE_LIMIT = 4000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hit_o,
  output logic             expired_o
);
  localparam int unsigned AGE_W = $clog2(PAGE_LIMIT + 1);

  logic             valid_q;
  logic [ROW_W-1:0] row_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      row_q   <= '0;
      age_q   <= '0;
    end else if (open_i) begin
      valid_q <= 1'b1;
      row_q   <= row_i;
      age_q   <= '0;
    end else if (close_i) begin
      valid_q <= 1'b0;
    end else if (valid_q && age_q != AGE_W'(PAGE_LIMIT)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign hit_o     = valid_q && (row_q == row_i);
  assign expired_o = valid_q && (age_q == AGE_W'(PAGE_LIMIT));
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int unsigned ROW_CYC = 1,
  parameter int unsigned CAS_CYC = 2,
  parameter int unsigned RP_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              gnt_i,
  input  edo_cmd_t          cmd_i,
  input  logic              hit_i,
  input  logic              expired_i,
  input  logic [DATA_W-1:0] dq_i,
  output edo_st_e           st_o,
  output edo_cmd_t          cmd_o,
  output logic              open_o,
  output logic              close_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned MAX_A = (ROW_CYC > CAS_CYC) ? ROW_CYC : CAS_CYC;
  localparam int unsigned MAX_C = (MAX_A > RP_CYC) ? MAX_A : RP_CYC;
  localparam int unsigned CNT_W = (MAX_C < 2) ? 1 : $clog2(MAX_C + 1);

  edo_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  edo_cmd_t          cmd_q;
  logic              load;
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cas_last;

  assign cas_last = (st_q == ST_CAS) && (cnt_q == '0);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    open_o  = 1'b0;
    close_o = 1'b0;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    unique case (st_q)
      ST_IDLE: if (req_i && gnt_i) begin
        st_d   = ST_ROW;
        cnt_d  = CNT_W'(ROW_CYC - 1);
        load   = 1'b1;
        open_o = 1'b1;
      end
      ST_ROW:  if (cnt_q == '0) st_d = ST_COLA;
      ST_COLA: begin
        st_d  = ST_CAS;
        cnt_d = CNT_W'(CAS_CYC - 1);
      end
      ST_CAS:  if (cnt_q == '0) st_d = ST_OPEN;
      ST_OPEN: if (!done_q) begin
        // grant loss, page age and row miss all close the row
        if (!gnt_i || expired_i || (req_i && !hit_i)) begin
          st_d    = ST_PRE;
          cnt_d   = CNT_W'(RP_CYC - 1);
          close_o = 1'b1;
        end else if (req_i) begin
          st_d = ST_COLA;
          load = 1'b1;
        end
      end
      ST_PRE:  if (cnt_q == '0) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= cas_last;
      if (load) cmd_q <= cmd_i;
      if (cas_last && !cmd_q.we) rdata_q <= dq_i;
    end
  end

  assign st_o    = st_q;
  assign cmd_o   = cmd_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/edo_pin_drv.sv
module edo_pin_drv
  import edo_pkg::*;
(
  input  edo_st_e           st_i,
  input  edo_cmd_t          cmd_i,
  output logic [DEVS-1:0]   ras_n_o,
  output logic [LANES-1:0]  cas_n_o,
  output logic [PIN_W-1:0]  a_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] dq_o
);
  logic row_act, col_ph, cas_act;

  assign row_act = (st_i == ST_ROW) || (st_i == ST_COLA) ||
                   (st_i == ST_CAS) || (st_i == ST_OPEN);
  assign col_ph  = (st_i == ST_COLA) || (st_i == ST_CAS);
  assign cas_act = (st_i == ST_CAS);

  for (genvar d = 0; d < DEVS; d++) begin : g_ras
    assign ras_n_o[d] = ~row_act;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cas
    assign cas_n_o[l] = ~(cas_act && (!cmd_i.we || cmd_i.be[l]));
  end

  assign a_o     = col_ph ? PIN_W'(cmd_i.col) : PIN_W'(cmd_i.row);
  // WE leads CAS by the column setup cycle: early write, outputs stay off
  assign we_n_o  = ~(col_ph && cmd_i.we);
  assign dq_oe_o = col_ph && cmd_i.we;
  assign oe_n_o  = ~(cas_act && !cmd_i.we);
  assign dq_o    = cmd_i.wdata;
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned ROW_CYC    = 1,
  parameter int unsigned CAS_CYC    = 2,
  parameter int unsigned RP_CYC     = 2,
  parameter int unsigned PAGE_LIMIT = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  be_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_idle_o,
  output logic [PIN_W-1:0]  dram_a_o,
  output logic [DEVS-1:0]   dram_ras_n_o,
  output logic [LANES-1:0]  dram_cas_n_o,
  output logic              dram_we_n_o,
  output logic              dram_oe_n_o,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  edo_cmd_t cmd_in, cmd_q;
  edo_st_e  st;
  logic     hit, expired, open_row, close_row;

  assign cmd_in = '{we: we_i, row: addr_i[ADDR_W-1:COL_W], col: addr_i[COL_W-1:0],
                    wdata: wdata_i, be: be_i};

  edo_page_track #(.PAGE_LIMIT(PAGE_LIMIT)) u_page (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (open_row),
    .close_i   (close_row),
    .row_i     (cmd_in.row),
    .hit_o     (hit),
    .expired_o (expired)
  );

  edo_seq #(.ROW_CYC(ROW_CYC), .CAS_CYC(CAS_CYC), .RP_CYC(RP_CYC)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .gnt_i     (gnt_i),
    .cmd_i     (cmd_in),
    .hit_i     (hit),
    .expired_i (expired),
    .dq_i      (dram_dq_i),
    .st_o      (st),
    .cmd_o     (cmd_q),
    .open_o    (open_row),
    .close_o   (close_row),
    .done_o    (done_o),
    .rdata_o   (rdata_o)
  );

  edo_pin_drv u_pins (
    .st_i    (st),
    .cmd_i   (cmd_q),
    .ras_n_o (dram_ras_n_o),
    .cas_n_o (dram_cas_n_o),
    .a_o     (dram_a_o),
    .we_n_o  (dram_we_n_o),
    .oe_n_o  (dram_oe_n_o),
    .dq_oe_o (dram_dq_oe_o),
    .dq_o    (dram_dq_o)
  );

  assign bus_idle_o = (st == ST_IDLE);
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk
  import edo_pkg::*;
#(
  parameter int unsigned PAGE_LIMIT = 4000,
  parameter int unsigned CAS_CYC    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [DEVS-1:0]  ras_n_i,
  input logic [LANES-1:0] cas_n_i,
  input logic             we_n_i,
  input logic             oe_n_i,
  input logic             dq_oe_i,
  input logic             done_i,
  input logic             idle_i
);
  logic [31:0] ras_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ras_low_cnt <= '0;
    else if (ras_n_i[0]) ras_low_cnt <= '0;
    else                 ras_low_cnt <= ras_low_cnt + 1;
  end

  assert_ras_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_n_i == '0 || ras_n_i == '1);

  assert_cas_in_row_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_n_i != '1 |-> ras_n_i == '0);

  assert_early_we_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_n_i != '1 && $past(cas_n_i) == '1 && !we_n_i) |-> !$past(we_n_i));

  assert_write_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_i |-> (!we_n_i && oe_n_i));

  assert_read_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_n_i != '1 && we_n_i) |-> !oe_n_i);

  assert_ras_to_cas_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_n_i != '1 && $past(cas_n_i) == '1) |-> (!$past(ras_n_i[0]) && !$past(ras_n_i[0], 2)));

  assert_precharge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_i[0]) |=> ras_n_i[0]);

  assert_page_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_low_cnt <= 32'(PAGE_LIMIT + CAS_CYC + 4));

  assert_idle_bus_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> (ras_n_i == '1 && cas_n_i == '1));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
endmodule

bind edo_ctrl edo_ctrl_chk #(.PAGE_LIMIT(PAGE_LIMIT), .CAS_CYC(CAS_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ras_n_i (dram_ras_n_o),
  .cas_n_i (dram_cas_n_o),
  .we_n_i  (dram_we_n_o),
  .oe_n_i  (dram_oe_n_o),
  .dq_oe_i (dram_dq_oe_o),
  .done_i  (done_o),
  .idle_i  (bus_idle_o)
);

// File: tb/edo_ctrl_tb_top.sv
module edo_ctrl_tb_top;
  localparam int LIM = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gnt, req, we;
  logic [19:0] addr;
  logic [31:0] wdata, rdata, dq_o;
  logic [31:0] dq_in = 32'hdeadbeef;
  logic [3:0]  be, cas_n;
  logic        done, bus_idle, we_n, oe_n, dq_oe;
  logic [9:0]  a;
  logic [1:0]  ras_n;

  always #10 clk = ~clk;

  edo_ctrl #(.PAGE_LIMIT(LIM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .done_o(done), .rdata_o(rdata),
    .bus_idle_o(bus_idle), .dram_a_o(a), .dram_ras_n_o(ras_n),
    .dram_cas_n_o(cas_n), .dram_we_n_o(we_n), .dram_oe_n_o(oe_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_in)
  );

  int h_chk = 0, h_bad = 0, m_chk = 0, m_bad = 0;
  int ras_fall_total = 0;

  logic        cur_we = 1'b0;
  logic [9:0]  cur_row = '0, cur_col = '0;
  logic [31:0] cur_wdata = '0;
  logic [3:0]  cur_be = '0;

  logic [31:0] dmem [0:1023];
  logic [31:0] emem [0:1023];
  logic [9:0]  drow = '0, dcol = '0;
  logic        prev_ras = 1'b1, prev_we = 1'b1;
  logic [3:0]  prev_cas = 4'hf;

  task automatic mchk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    m_chk++;
    if (!ok) begin
      m_bad++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  task automatic hchk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    h_chk++;
    if (!ok) begin
      h_bad++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  // behavioural DRAM and pin monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) dmem[i] = 32'h5a000000 + i * 32'h00010101;
      dq_in = 32'hdeadbeef;
    end else begin
      if (prev_ras && !ras_n[0]) begin
        drow = a;
        ras_fall_total++;
        mchk(a == cur_row, "R2 row at RAS fall", {22'b0, a}, {22'b0, cur_row});
      end
      mchk(ras_n[0] == ras_n[1], "R3 RAS pair", {30'b0, ras_n}, {30'b0, {2{ras_n[0]}}});
      if (cas_n != 4'hf)
        mchk(ras_n == 2'b00, "R3 CAS only inside RAS", {30'b0, ras_n}, 32'h0);
      if (prev_cas == 4'hf && cas_n != 4'hf) begin
        dcol = a;
        mchk(a == cur_col, "R2 column at CAS fall", {22'b0, a}, {22'b0, cur_col});
        if (cur_we) begin
          mchk(cas_n == ~cur_be, "R4 write lanes", {28'b0, cas_n}, {28'b0, ~cur_be});
          mchk(!prev_we && !we_n, "R5 WE ahead of CAS", {31'b0, prev_we}, 32'h0);
          mchk(oe_n && dq_oe, "R5 OE off, bus driven", {30'b0, oe_n, dq_oe}, 32'h3);
          mchk(dq_o == cur_wdata, "R5 write data", dq_o, cur_wdata);
          for (int l = 0; l < 4; l++)
            if (!cas_n[l]) dmem[{drow[4:0], a[4:0]}][8*l +: 8] = dq_o[8*l +: 8];
        end else begin
          mchk(cas_n == 4'h0, "R4 read lanes", {28'b0, cas_n}, 32'h0);
          mchk(!oe_n && !dq_oe, "R6 OE on, bus released", {30'b0, oe_n, dq_oe}, 32'h0);
        end
      end
      dq_in = (cas_n != 4'hf && !oe_n) ? dmem[{drow[4:0], dcol[4:0]}] : 32'hdeadbeef;
    end
    prev_ras = ras_n[0];
    prev_cas = cas_n;
    prev_we  = we_n;
  end

  task automatic do_req(input bit w, input int r, input int c, input logic [31:0] wd,
                        input logic [3:0] b, input int hold, input int exp_lat,
                        input int exp_falls, input string tag);
    int base, lat, idx;
    idx = r * 32 + c;
    cur_we = w; cur_row = 10'(r); cur_col = 10'(c); cur_wdata = wd; cur_be = b;
    base = ras_fall_total;
    we = w; addr = {10'(r), 10'(c)}; wdata = wd; be = b; req = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      hchk(!done && ras_n == 2'b11, {tag, " held while grant low"}, {29'b0, done, ras_n}, 32'h3);
    end
    if (hold > 0) gnt = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 40);
    req = 1'b0;
    hchk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    hchk(ras_fall_total - base == exp_falls, {tag, " RAS falls"}, ras_fall_total - base, exp_falls);
    if (!w) hchk(rdata == emem[idx], {tag, " R6 read data"}, rdata, emem[idx]);
    else
      for (int l = 0; l < 4; l++) if (b[l]) emem[idx][8*l +: 8] = wd[8*l +: 8];
    @(negedge clk);
    hchk(!done, "R12 done single cycle", {31'b0, done}, 32'h0);
    @(negedge clk);
  endtask

  initial begin
    gnt = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; be = '0;
    for (int i = 0; i < 1024; i++) emem[i] = 32'h5a000000 + i * 32'h00010101;
    repeat (3) @(negedge clk);
    // R1 reset state
    hchk(ras_n == 2'b11 && cas_n == 4'hf, "R1 strobes idle", {26'b0, ras_n, cas_n}, 32'h3f);
    hchk(we_n && oe_n && !dq_oe, "R1 WE/OE/bus", {29'b0, we_n, oe_n, dq_oe}, 32'h6);
    hchk(!done && bus_idle, "R1 done/idle", {30'b0, done, bus_idle}, 32'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_req(1'b1, 3, 5, 32'h11223344, 4'hf, 0, 5, 1, "R7 cold write");
    do_req(1'b0, 3, 5, '0, 4'hf, 0, 4, 0, "R8 hit read");
    do_req(1'b1, 3, 5, 32'haabbccdd, 4'b0101, 0, 4, 0, "R4 hit partial write");
    do_req(1'b0, 3, 5, '0, 4'hf, 0, 4, 0, "R4 merged read");
    do_req(1'b0, 3, 6, '0, 4'hf, 0, 4, 0, "R8 hit other column");
    do_req(1'b1, 7, 1, 32'hcafe0000, 4'b1000, 0, 8, 1, "R9 miss write");
    do_req(1'b0, 7, 1, '0, 4'hf, 0, 4, 0, "R9 read after miss");

    // R10 page age close
    repeat (10) @(negedge clk);
    hchk(!bus_idle && ras_n == 2'b00, "R10 row still open", {30'b0, bus_idle, ras_n[0]}, 32'h0);
    repeat (60) @(negedge clk);
    hchk(bus_idle && ras_n == 2'b11, "R10 row closed by age", {30'b0, bus_idle, ras_n[0]}, 32'h3);
    do_req(1'b0, 7, 1, '0, 4'hf, 0, 5, 1, "R10 reopen after age close");

    // R11 grant taken away
    gnt = 1'b0;
    repeat (5) @(negedge clk);
    hchk(bus_idle && ras_n == 2'b11, "R11 idle after grant loss", {30'b0, bus_idle, ras_n[0]}, 32'h3);
    do_req(1'b0, 7, 1, '0, 4'hf, 6, 5, 1, "R11 served on grant");
    do_req(1'b0, 3, 5, '0, 4'hf, 0, 8, 1, "R9 miss back to row 3");

    $display("test done: total=%0d bad=%0d", h_chk + m_chk, h_bad + m_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", h_chk + m_chk + 1, h_bad + m_bad + 1);
    $finish;
  end
endmodule